// File: doc/BRIEF.md
# Dual-Rail Power-Up Sequencer

This controller decides, clock by clock, which of two regulator rails may be switched on. An active-low enable input starts the rails. A select input picks which rail leads. The trailing rail is released only once the leading rail's undervoltage comparator reports that the leading rail has reached about 83% of its target. If the leading rail later sags below that level, the trailing rail is pulled back. A fault on the trailing rail leaves the leading rail running.

An input-supply-valid flag and a thermal-fault flag act as master interlocks. Either one forces both rails off at once. When both interlocks are good again, the rails restart through the normal order. Each rail has an output-discharge control that is active whenever that rail is off.

Falling edges on the enable, the select and both comparator flags pass through deglitch filters. The filter lengths are parameters given in clock cycles, and a rising edge passes straight through. The filter on the select input resets high, so the block treats the select as high, with rail 2 leading, until a low level has been held for a full filter window.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While the filtered enable is high (block disabled), both rail enables are low. A rise on `en_n` turns both rails off two clock edges after it is sampled.
- R2: With select high, rail 2 is enabled first. Rail 1 is enabled two edges after `uv2_ok` is sampled high.
- R3: With select low, rail 1 is enabled first. Rail 2 is enabled two edges after `uv1_ok` is sampled high.
- R4: If the leading rail's filtered comparator flag drops, the trailing rail turns off on the next edge, and it returns once the flag is high again. A low flag on the trailing rail never turns off the leading rail.
- R5: The rail order is taken from the filtered select only while both rails are off. A change of select while the rails run has no effect until the next off period.
- R6: A low level on `en_n`, `seq_sel`, `uv1_ok` or `uv2_ok` is acted on only after it has been sampled for the full filter length of that input. A shorter low pulse changes no output.
- R7: While `supply_ok` is low, both rails are off: they turn off one edge after it is sampled low, and no rail starts while it stays low.
- R8: While `therm_fault` is high, both rails are off: they turn off one edge after it is sampled high. After it clears, the leading rail returns on the next edge and the trailing rail follows through the normal order.
- R9: Each discharge output is high exactly when the enable of the same rail is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_n | input | 1 | Active-low block enable |
| seq_sel | input | 1 | 1: rail 2 leads, 0: rail 1 leads |
| supply_ok | input | 1 | Input supply above lockout level |
| therm_fault | input | 1 | Thermal shutdown request |
| uv1_ok | input | 1 | Rail 1 at or above 83% of target |
| uv2_ok | input | 1 | Rail 2 at or above 83% of target |
| rail1_en | output | 1 | Rail 1 pass-device enable |
| rail2_en | output | 1 | Rail 2 pass-device enable |
| rail1_dis | output | 1 | Rail 1 output-discharge control |
| rail2_dis | output | 1 | Rail 2 output-discharge control |

## Verification
The bench builds the block with filter lengths of 4 cycles for the enable, 3 for the select and 5 for the comparator flags. At the default lengths of several thousand cycles, a run would spend almost all of its time waiting out filter windows. With these short and unequal lengths, the tests can hit both edges of every window: a glitch one sample shorter than the window, and a low held exactly long enough. They also leave room to run both rail orders, trailing faults, leading-rail sags and both interlocks in one short run.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_LEAD = 2'd1,
    ST_BOTH = 2'd2
  } seq_state_e;

  // counter width able to hold values up to n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // maps lead/trail activity onto a physical rail
  function automatic logic rail_on(input logic is_rail1, input logic r1_first,
                                   input logic lead, input logic trail);
    return (is_rail1 == r1_first) ? lead : trail;
  endfunction

endpackage

// File: rtl/rail_seq_deglitch.sv
module rail_seq_deglitch
  import rail_seq_pkg::*;
#(
  parameter int unsigned LEN     = 4,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] low_cnt;
  logic          q;

  // rising edge passes at once, a low must be seen LEN samples in a row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      q       <= RST_VAL;
    end else if (din) begin
      low_cnt <= '0;
      q       <= 1'b1;
    end else if (low_cnt == LAST) begin
      q       <= 1'b0;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign dout = q;
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_ok,
  input  logic sel_f,
  input  logic uv1_f,
  input  logic uv2_f,
  output logic lead_on,
  output logic trail_on,
  output logic r1_first,
  output logic lead_uv
);
  seq_state_e state, state_nx;
  logic       order_r1;

  assign lead_uv = order_r1 ? uv1_f : uv2_f;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_OFF:  if (run_ok) state_nx = ST_LEAD;
      ST_LEAD: if (!run_ok) state_nx = ST_OFF;
               else if (lead_uv) state_nx = ST_BOTH;
      ST_BOTH: if (!run_ok) state_nx = ST_OFF;
               else if (!lead_uv) state_nx = ST_LEAD;
      default: state_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      order_r1 <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_OFF) order_r1 <= ~sel_f;
    end
  end

  assign lead_on  = (state != ST_OFF);
  assign trail_on = (state == ST_BOTH);
  assign r1_first = order_r1;
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int unsigned DG_EN_CYC  = 7000,
  parameter int unsigned DG_SEQ_CYC = 7000,
  parameter int unsigned DG_UV_CYC  = 7000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_n,
  input  logic seq_sel,
  input  logic supply_ok,
  input  logic therm_fault,
  input  logic uv1_ok,
  input  logic uv2_ok,
  output logic rail1_en,
  output logic rail2_en,
  output logic rail1_dis,
  output logic rail2_dis
);
  localparam int unsigned NUV = 2;

  logic           en_off_f;
  logic           sel_f;
  logic [NUV-1:0] uv_raw;
  logic [NUV-1:0] uv_f;
  logic           run_ok;
  logic           lead_on, trail_on, r1_first, lead_uv_f;

  rail_seq_deglitch #(.LEN(DG_EN_CYC), .RST_VAL(1'b1)) i_dg_en (
    .clk(clk), .rst_n(rst_n), .din(en_n), .dout(en_off_f));

  rail_seq_deglitch #(.LEN(DG_SEQ_CYC), .RST_VAL(1'b1)) i_dg_sel (
    .clk(clk), .rst_n(rst_n), .din(seq_sel), .dout(sel_f));

  assign uv_raw = {uv2_ok, uv1_ok};

  for (genvar g = 0; g < NUV; g++) begin : g_uv
    rail_seq_deglitch #(.LEN(DG_UV_CYC), .RST_VAL(1'b0)) i_dg_uv (
      .clk(clk), .rst_n(rst_n), .din(uv_raw[g]), .dout(uv_f[g]));
  end

  assign run_ok = ~en_off_f & supply_ok & ~therm_fault;

  rail_seq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .sel_f(sel_f),
    .uv1_f(uv_f[0]), .uv2_f(uv_f[1]),
    .lead_on(lead_on), .trail_on(trail_on), .r1_first(r1_first),
    .lead_uv(lead_uv_f));

  assign rail1_en  = rail_on(1'b1, r1_first, lead_on, trail_on);
  assign rail2_en  = rail_on(1'b0, r1_first, lead_on, trail_on);
  assign rail1_dis = ~rail1_en;
  assign rail2_dis = ~rail2_en;
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic therm_fault,
  input logic en_off_f,
  input logic lead_on,
  input logic trail_on,
  input logic lead_uv_f,
  input logic r1_first,
  input logic rail1_en,
  input logic rail2_en
);
  a_r1_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
    en_off_f |=> (!rail1_en && !rail2_en));

  a_r2_trail_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail1_en && rail2_en) |-> $past(rail1_en || rail2_en));

  a_r4_lead_sag_drops_trail: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_on && !lead_uv_f) |=> !trail_on);

  a_r5_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_on && $past(lead_on)) |-> $stable(r1_first));

  a_r7_supply_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!rail1_en && !rail2_en));

  a_r8_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
    therm_fault |=> (!rail1_en && !rail2_en));
endmodule

bind rail_seq_ctrl rail_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .therm_fault(therm_fault),
  .en_off_f(en_off_f), .lead_on(lead_on), .trail_on(trail_on),
  .lead_uv_f(lead_uv_f), .r1_first(r1_first),
  .rail1_en(rail1_en), .rail2_en(rail2_en));

// File: tb/test_rail_seq_ctrl.sv
module test_rail_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1, seq_sel = 1'b1, supply_ok = 1'b1, therm_fault = 1'b0;
  logic uv1_ok = 1'b0, uv2_ok = 1'b0;
  logic rail1_en, rail2_en, rail1_dis, rail2_dis;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    logic  e1;
    logic  e2;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rail_seq_ctrl #(.DG_EN_CYC(4), .DG_SEQ_CYC(3), .DG_UV_CYC(5)) i_rail_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .seq_sel(seq_sel),
    .supply_ok(supply_ok), .therm_fault(therm_fault),
    .uv1_ok(uv1_ok), .uv2_ok(uv2_ok),
    .rail1_en(rail1_en), .rail2_en(rail2_en),
    .rail1_dis(rail1_dis), .rail2_dis(rail2_dis));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expect rail enables after n more rising edges
  task automatic expect_at(input int n, input logic e1, input logic e2, input string tag);
    exp_t it;
    it.due = cyc + n; it.e1 = e1; it.e2 = e2; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares queued items a little after the edge they are due on
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t it;
        it = sb.pop_front();
        total++;
        if (it.due < cyc) begin
          bad++;
          $display("FAIL %s: missed sample (due %0d, now %0d)", it.tag, it.due, cyc);
        end else if (rail1_en !== it.e1 || rail2_en !== it.e2) begin
          bad++;
          $display("FAIL %s: en1/en2 actual %b%b expected %b%b",
                   it.tag, rail1_en, rail2_en, it.e1, it.e2);
        end
        total++;
        if (rail1_dis !== ~rail1_en || rail2_dis !== ~rail2_en) begin
          bad++;
          $display("FAIL R9 (%s): dis1/dis2 actual %b%b expected %b%b",
                   it.tag, rail1_dis, rail2_dis, ~rail1_en, ~rail2_en);
        end
      end
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_at(1, 0, 0, "R1 reset state");
    tick(1);
    // R6: select glitch shorter than its window leaves rail 2 leading
    seq_sel = 1'b0; tick(2); seq_sel = 1'b1;
    en_n = 1'b0;
    expect_at(4, 0, 0, "R6 enable window not yet met");
    expect_at(5, 0, 1, "R2 rail2 leads");
    tick(5);
    uv2_ok = 1'b1;
    expect_at(1, 0, 1, "R2 rail1 still waiting");
    expect_at(2, 1, 1, "R2 rail1 follows");
    tick(2);
    uv1_ok = 1'b1; tick(3); uv1_ok = 1'b0; tick(10);
    expect_at(1, 1, 1, "R4 trailing fault keeps lead");
    tick(1);
    uv2_ok = 1'b0; tick(4); uv2_ok = 1'b1;
    expect_at(3, 1, 1, "R6 uv glitch ignored");
    tick(3);
    uv2_ok = 1'b0;
    expect_at(5, 1, 1, "R6 uv window edge");
    expect_at(6, 0, 1, "R4 lead sag drops trail");
    tick(6);
    uv2_ok = 1'b1;
    expect_at(2, 1, 1, "R4 trail returns");
    tick(2);
    seq_sel = 1'b0; tick(10);
    expect_at(1, 1, 1, "R5 select change ignored while running");
    tick(1);
    en_n = 1'b1;
    expect_at(1, 1, 1, "R1 off latency");
    expect_at(2, 0, 0, "R1 disable");
    tick(2);
    en_n = 1'b0;
    expect_at(5, 1, 0, "R3 rail1 leads");
    tick(5);
    uv1_ok = 1'b1;
    expect_at(2, 1, 1, "R3 rail2 follows");
    tick(2);
    uv2_ok = 1'b0; tick(10);
    expect_at(1, 1, 1, "R4 trailing fault with select low");
    tick(1);
    uv2_ok = 1'b1;
    therm_fault = 1'b1;
    expect_at(1, 0, 0, "R8 thermal off");
    tick(3);
    therm_fault = 1'b0;
    expect_at(1, 1, 0, "R8 restart lead");
    expect_at(2, 1, 1, "R8 restart trail");
    tick(2);
    supply_ok = 1'b0;
    expect_at(1, 0, 0, "R7 supply loss");
    tick(10);
    expect_at(1, 0, 0, "R7 held off");
    tick(1);
    supply_ok = 1'b1;
    expect_at(1, 1, 0, "R7 resume lead");
    expect_at(2, 1, 1, "R7 resume trail");
    tick(2);
    en_n = 1'b1; tick(3);
    en_n = 1'b0; tick(3); en_n = 1'b1;
    expect_at(3, 0, 0, "R6 enable glitch ignored");
    tick(3);
    supply_ok = 1'b0; en_n = 1'b0; tick(10);
    expect_at(1, 0, 0, "R7 lockout blocks start");
    tick(1);
    supply_ok = 1'b1;
    expect_at(1, 1, 0, "R7 start after supply");
    expect_at(2, 1, 1, "R7 trail after supply");
    tick(4);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 5000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual cyc=%0d expected finish before 5000", cyc);
    end
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule